// File: doc/BRIEF.md
# Sigma-Delta Loop Feedback Filter

This block lives in the digital return path of a multi-bit sigma-delta modulator that has a single feedback point. On every accepted sample it takes the thermometer word of the flash quantizer and turns it into a signed level. It passes that level through a short transversal filter with integer weights. It then encodes the filtered value as a wider thermometer word, which drives the unit elements of the feedback DAC. The DAC therefore sees a weighted mix of the present and past quantizer decisions, not the quantizer code alone. This is why its word is several times wider than the quantizer word.

A mode pin selects the filter. The third-order setting uses weights 3, −3, +1 over the current and two previous samples. The second-order setting uses weights 2, −1 over the current and one previous sample. The mode is fixed while the block runs and is changed only under reset. Results beyond the element range are clipped, and a sticky flag records every clip. A non-monotonic quantizer word is still decoded, by counting its ones, and it is flagged.

Top module: `fbk_loop_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the output register is loaded with a centred word. That word has 23 elements on in third-order mode (`mode_i`=1) and 5 elements on in second-order mode (`mode_i`=0). At the same edge `bubble_o` and `sat_o` are cleared.
- R2: The quantizer level is a = 2·n − 11, where n is the number of ones in `therm_i` (11 bits). The position of the ones does not matter, so a non-monotonic word decodes to the same level as a clean word with the same number of ones.
- R3: In third-order mode, y = 3·a[k] − 3·a[k−1] + a[k−2]. The DAC word has m = (y + 47)/2 elements on, clipped to the range 0 to 47. It is a thermometer word: bits 0 to m−1 are set and all other bits are clear.
- R4: In second-order mode, y = 2·a[k] − a[k−1]. The DAC word has m = (y + 11)/2 elements on, clipped to the range 0 to 11, as bits 0 to m−1. Bits 11 to 46 are always zero in this mode.
- R5: A sample with `in_vld` high changes `dac_o` and `bubble_o` one clock edge after it is presented. A cycle with `in_vld` low leaves both outputs unchanged and does not shift the history.
- R6: `bubble_o` is registered together with the DAC word. It is 1 when the accepted word is not of the form "ones in bits 0 to n−1, zeros above".
- R7: `sat_o` is set at the edge that registers a clipped sample. Otherwise, `sat_clr` high clears it at the next edge. When neither happens, it holds.
- R8: The history taps hold level 0 after reset, so the first samples after reset use zero for the earlier terms.
- R9: `dac_o` is always a thermometer word.
- R10: `mode_i` is stable whenever `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 1 = third-order filter, 0 = second-order filter |
| in_vld | input | 1 | Quantizer sample present this cycle |
| therm_i | input | 11 | Quantizer comparator outputs |
| sat_clr | input | 1 | Clear request for the saturation flag |
| dac_o | output | 47 | Registered unit-element DAC word |
| bubble_o | output | 1 | Last accepted quantizer word was non-monotonic |
| sat_o | output | 1 | Sticky clip indicator |

## Verification
The bench builds the block with its default 12-level quantizer and 48-level and 12-level DAC ranges. At that size the full set of three consecutive quantizer counts is only 1728 triples, so both modes are swept over every triple. This covers every filter value that can occur, including the clipped extremes at both ends. Full-scale alternating input, non-monotonic words, idle cycles between samples, and flag clearing are added as directed sequences, and all of them are compared with an arithmetic model.

// File: rtl/fbk_pkg.sv
package fbk_pkg;

  typedef logic signed [15:0] lvl_t;

  typedef enum logic {MODE_SECOND = 1'b0, MODE_THIRD = 1'b1} fmode_e;

  typedef struct packed {
    logic [15:0] cnt;
    logic        hi;
    logic        lo;
  } scale_t;

  // doubled centred level: 2*ones - comparators
  function automatic lvl_t centre_level(input int ones, input int comps);
    return lvl_t'(2 * ones - comps);
  endfunction

  function automatic lvl_t fir_third(input lvl_t a0, input lvl_t a1, input lvl_t a2);
    return (a0 <<< 1) + a0 - (a1 <<< 1) - a1 + a2;
  endfunction

  function automatic lvl_t fir_second(input lvl_t a0, input lvl_t a1);
    return (a0 <<< 1) - a1;
  endfunction

  // doubled filter value -> element count, clipped to [0, elems]
  function automatic scale_t rescale(input lvl_t y2, input int elems);
    scale_t r;
    int     s;
    s = int'(y2) + elems;
    r = '0;
    if (s < 0) begin
      r.lo = 1'b1;
    end else if (s > 2 * elems) begin
      r.hi  = 1'b1;
      r.cnt = 16'(elems);
    end else begin
      r.cnt = 16'(s / 2);
    end
    return r;
  endfunction

endpackage

// File: rtl/fbk_therm_decode.sv
module fbk_therm_decode #(
  parameter int IN_W = 11,
  localparam int CW = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0] word,
  output logic [CW-1:0]   ones,
  output logic            bubble
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < IN_W; i++) begin
      ones = ones + CW'(word[i]);
    end
  end

  // clean code is 0..01..1: adding one must not hit a set bit
  assign bubble = |(word & (word + IN_W'(1)));

endmodule

// File: rtl/fbk_tap_filter.sv
module fbk_tap_filter
  import fbk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic mode,
  input  lvl_t level,
  output lvl_t y2
);

  lvl_t tap1, tap2;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap1 <= '0;
      tap2 <= '0;
    end else if (adv) begin
      tap1 <= level;
      tap2 <= tap1;
    end
  end

  always_comb begin
    if (mode == MODE_THIRD) y2 = fir_third(level, tap1, tap2);
    else                    y2 = fir_second(level, tap1);
  end

endmodule

// File: rtl/fbk_therm_encode.sv
module fbk_therm_encode
  import fbk_pkg::*;
#(
  parameter int OUT_W  = 47,
  parameter int OUT2_W = 11
) (
  input  logic             mode,
  input  lvl_t             y2,
  output logic [OUT_W-1:0] word,
  output logic             clip_hi,
  output logic             clip_lo
);

  scale_t sc;
  int     on_cnt;

  always_comb begin
    sc     = rescale(y2, (mode == MODE_THIRD) ? OUT_W : OUT2_W);
    on_cnt = int'(sc.cnt);
  end

  assign clip_hi = sc.hi;
  assign clip_lo = sc.lo;

  for (genvar i = 0; i < OUT_W; i++) begin : g_elem
    assign word[i] = (on_cnt > i);
  end

endmodule

// File: rtl/fbk_loop_filter.sv
module fbk_loop_filter
  import fbk_pkg::*;
#(
  parameter int IN_LEVELS     = 12,
  parameter int OUT_LEVELS_HI = 48,
  parameter int OUT_LEVELS_LO = 12,
  localparam int IN_W   = IN_LEVELS - 1,
  localparam int OUT_W  = OUT_LEVELS_HI - 1,
  localparam int OUT2_W = OUT_LEVELS_LO - 1,
  localparam int CW     = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  therm_i,
  input  logic             sat_clr,
  output logic [OUT_W-1:0] dac_o,
  output logic             bubble_o,
  output logic             sat_o
);

  logic [CW-1:0]    ones;
  logic             bub_evt;
  lvl_t             level;
  lvl_t             y2;
  logic [OUT_W-1:0] enc_word;
  logic [OUT_W-1:0] mid_word;
  logic             clip_hi, clip_lo, clip_evt;
  int               mid_cnt;

  fbk_therm_decode #(.IN_W(IN_W)) dec_i (
    .word   (therm_i),
    .ones   (ones),
    .bubble (bub_evt)
  );

  assign level = centre_level(int'(ones), IN_W);

  fbk_tap_filter flt_i (
    .clk   (clk),
    .rst   (rst),
    .adv   (in_vld),
    .mode  (mode_i),
    .level (level),
    .y2    (y2)
  );

  fbk_therm_encode #(.OUT_W(OUT_W), .OUT2_W(OUT2_W)) enc_i (
    .mode    (mode_i),
    .y2      (y2),
    .word    (enc_word),
    .clip_hi (clip_hi),
    .clip_lo (clip_lo)
  );

  assign clip_evt = in_vld & (clip_hi | clip_lo);
  assign mid_cnt  = (mode_i == MODE_THIRD) ? OUT_W / 2 : OUT2_W / 2;

  for (genvar i = 0; i < OUT_W; i++) begin : g_mid
    assign mid_word[i] = (mid_cnt > i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_o    <= mid_word;
      bubble_o <= 1'b0;
      sat_o    <= 1'b0;
    end else begin
      if (in_vld) begin
        dac_o    <= enc_word;
        bubble_o <= bub_evt;
      end
      if (clip_evt)     sat_o <= 1'b1;
      else if (sat_clr) sat_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fbk_loop_filter_chk.sv
module fbk_loop_filter_chk #(
  parameter int OUT_W  = 47,
  parameter int OUT2_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_i,
  input logic             in_vld,
  input logic             sat_clr,
  input logic [OUT_W-1:0] dac_o,
  input logic             bubble_o,
  input logic             sat_o,
  input logic             clip_hi,
  input logic             clip_lo,
  input logic             bub_evt
);

  logic [OUT_W:0] ext;
  assign ext = {1'b0, dac_o};

  p_therm_shape_r9: assert property (@(posedge clk) disable iff (rst)
    ((ext + (OUT_W + 1)'(1)) & ext) == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(dac_o) && $stable(bubble_o)));

  p_mode_stable_r10: assert property (@(posedge clk) disable iff (rst)
    $stable(mode_i));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_i |-> (dac_o[OUT_W-1:OUT2_W] == '0));

  p_clip_top_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_i && in_vld && clip_hi) |=> (&dac_o));

  p_clip_bottom_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && clip_lo) |=> (dac_o == '0));

  p_sat_set_r7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (clip_hi || clip_lo)) |=> sat_o);

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sat_o && !sat_clr) |=> sat_o);

  p_bubble_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && bub_evt) |=> bubble_o);

endmodule

bind fbk_loop_filter fbk_loop_filter_chk #(.OUT_W(OUT_W), .OUT2_W(OUT2_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode_i   (mode_i),
  .in_vld   (in_vld),
  .sat_clr  (sat_clr),
  .dac_o    (dac_o),
  .bubble_o (bubble_o),
  .sat_o    (sat_o),
  .clip_hi  (clip_hi),
  .clip_lo  (clip_lo),
  .bub_evt  (bub_evt)
);

// File: tb/fbk_loop_filter_tb_top.sv
module fbk_loop_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_i = 1'b1;
  logic        in_vld = 1'b0;
  logic [10:0] therm_i = '0;
  logic        sat_clr = 1'b0;
  logic [46:0] dac_o;
  logic        bubble_o;
  logic        sat_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  int    h1, h2;
  logic [63:0] exp_dac;
  logic  exp_bub, exp_sat;

  always #10 clk = ~clk;

  fbk_loop_filter dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .in_vld(in_vld),
    .therm_i(therm_i), .sat_clr(sat_clr),
    .dac_o(dac_o), .bubble_o(bubble_o), .sat_o(sat_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ones_word(input int n);
    logic [63:0] w = '0;
    for (int i = 0; i < n; i++) w[i] = 1'b1;
    return w;
  endfunction

  function automatic logic [10:0] clean(input int n);
    return ones_word(n) [10:0];
  endfunction

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode_i = m; in_vld = 1'b0; sat_clr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    h1 = 0; h2 = 0;
    exp_dac = ones_word(m ? 23 : 5);
    exp_bub = 1'b0; exp_sat = 1'b0;
    #1;
    chk("R1 dac", {17'b0, dac_o}, exp_dac);
    chk("R1 bubble", {63'b0, bubble_o}, {63'b0, exp_bub});
    chk("R1 sat", {63'b0, sat_o}, {63'b0, exp_sat});
  endtask

  task automatic send(input logic [10:0] w, input logic v, input logic clr, input string tag);
    int n, a, y, e, half, on;
    bit seen0, bub, clipped;
    @(negedge clk);
    therm_i = w; in_vld = v; sat_clr = clr;
    n = 0; seen0 = 0; bub = 0;
    for (int i = 0; i < 11; i++) begin
      if (w[i]) begin n++; if (seen0) bub = 1; end
      else seen0 = 1;
    end
    clipped = 0;
    if (v) begin
      a = 2 * n - 11;
      if (mode_i) begin y = 3 * a - 3 * h1 + h2; e = 47; end
      else        begin y = 2 * a - h1;          e = 11; end
      half = y + e;
      if (half < 0)          begin on = 0; clipped = 1; end
      else if (half > 2 * e) begin on = e; clipped = 1; end
      else on = half / 2;
      exp_dac = ones_word(on);
      exp_bub = bub;
      h2 = h1; h1 = a;
    end
    if (v && clipped) exp_sat = 1'b1;
    else if (clr)     exp_sat = 1'b0;
    @(posedge clk);
    #2;
    chk(tag, {17'b0, dac_o}, exp_dac);
    chk("R6 bubble", {63'b0, bubble_o}, {63'b0, exp_bub});
    chk("R7 sat", {63'b0, sat_o}, {63'b0, exp_sat});
  endtask

  task automatic session(input logic m);
    string t;
    t = m ? "R3" : "R4";
    do_reset(m);
    send(clean(11), 1'b1, 1'b0, "R8 first");
    send(clean(0), 1'b1, 1'b0, "R8 second");
    // exhaustive triples of counts
    for (int idx = 0; idx < 1728; idx++) begin
      send(clean(idx / 144), 1'b1, 1'b0, t);
      send(clean((idx / 12) % 12), 1'b1, 1'b0, t);
      send(clean(idx % 12), 1'b1, 1'b0, t);
    end
    // full-scale alternation
    for (int k = 0; k < 16; k++) send(clean((k % 2) ? 0 : 11), 1'b1, 1'b0, t);
    // idle cycles with changing garbage: no effect
    send(11'h555, 1'b0, 1'b0, "R5 hold");
    send(11'h7FF, 1'b0, 1'b0, "R5 hold");
    send(clean(6), 1'b1, 1'b0, "R5 resume");
    // non-monotonic words decode by count
    send(11'b00000000101, 1'b1, 1'b0, "R2 bubble");
    send(11'b10000000000, 1'b1, 1'b0, "R2 bubble");
    send(11'b01111101111, 1'b1, 1'b0, "R2 bubble");
    send(clean(6), 1'b1, 1'b0, "R2 clean");
    send(clean(6), 1'b1, 1'b0, "R2 clean");
    // clear sticky flag
    send(clean(6), 1'b0, 1'b1, "R7 clear");
    send(clean(6), 1'b1, 1'b0, "R7 quiet");
    send(clean(11), 1'b1, 1'b1, "R7 set wins");
    send(clean(11), 1'b1, 1'b0, "R7 set");
  endtask

  initial begin
    session(1'b1);
    session(1'b0);
    session(1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule